// File: doc/BRIEF.md
# I2C-Controlled Parallel Port with Shared DAC Code Latches

This block is the digital core of a serial-controlled tuning device when it runs in its port-expander configuration. One I2C slave serves two things: a bank of 8-bit DAC code latches and a bidirectional parallel port. The top bit of the 3-bit address strap also sets how they are split. With the strap bit low there are four DAC latches and an 8-bit port. With it high there are eight DAC latches and a 4-bit port that uses the low nibble.

A write transfer carries a selector byte after the address. The low four bits of the selector decide where the following data goes: a single port write, one DAC latch, or a continuous stream of port writes. A read transfer has no selector. It samples the port inputs and shifts them out on SDA, one byte per master acknowledge, until the master answers with a NACK. A read places the port in high impedance, and the port stays there until a later port write is acknowledged.

SCL and SDA are oversampled by the system clock through a synchronizer. The block drives SDA only low, through an open-drain enable. The analog converters that follow the code latches are outside this block.

Top module: `pexp_top`

## Requirements
- R1: After reset, port_oe is 0, port_out is 0, every DAC code is 0, and SDA is not driven.
- R2: The slave responds only to the 7-bit address {1001, addr_strap[2:0]}, with bit 0 of the first byte as R/W (1 = read). Any other address is not acknowledged and changes nothing.
- R3: In a write transfer, the first data byte is a selector, and only its low four bits are decoded. Code 0000 drives the next byte onto port_out with port_oe = 1. Later bytes in the same transfer have no effect.
- R4: Selector codes 0001 to 0100 load the next byte into DAC channel 1 to 4 (dac_codes bits [8k-1:8k-8] for channel k). Later bytes in the same transfer have no effect.
- R5: Selector codes 0101 to 1000 load DAC channels 5 to 8 only when addr_strap[2] = 1. When addr_strap[2] = 0 they have no effect.
- R6: Selector code 1111 drives every following byte onto the port in turn until STOP or repeated START. The last byte remains on port_out.
- R7: A read returns the port inputs, MSB first. The first byte is sampled at the SCL fall that ends the address acknowledge, and each later byte at the SCL fall that ends a master ACK. A master NACK ends the read and SDA is released.
- R8: When addr_strap[2] = 1, bits 7:4 of port_out are always 0 and bits 7:4 of read data are returned as 0.
- R9: A read transfer clears port_oe. port_oe stays 0 through DAC writes and rises only when a port write byte is acknowledged.
- R10: Selector codes 1001 to 1110 are acknowledged together with their data bytes, and change no output.
- R11: The slave acknowledges a matching address and every byte written to it by pulling SDA low in the ninth bit. It changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_strap | input | 3 | Low address bits; bit 2 also selects the channel/port split |
| port_in | input | 8 | Parallel port input pins |
| port_out | output | 8 | Parallel port output value |
| port_oe | output | 1 | Parallel port output enable (0 = high impedance) |
| dac_codes | output | 64 | Eight 8-bit DAC codes, channel 1 in bits 7:0 |

## Verification
Every event on the bus reaches the logic about three clock cycles after the SCL edge, because of the synchronizer and edge detector. Register updates then land one cycle later. A port or latch update appears about four cycles after the SCL fall that starts the acknowledge bit. A read byte is loaded about four cycles after the SCL fall that ends the preceding acknowledge.

The bench keeps each SCL quarter period at eight cycles. It checks the port and the latches only after STOP plus a further quarter period. It changes port_in for the next read byte during the bit before that byte's sampling fall, so the value expected for each byte is unambiguous.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

    localparam int BYTE_W   = 8;
    localparam int CH_TOTAL = 8;
    localparam int CH_HALF  = CH_TOTAL / 2;
    localparam int CH_IDX_W = $clog2(CH_TOTAL);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACK,
        PH_RX,
        PH_TX,
        PH_MACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        WM_NONE,
        WM_PORT_ONE,
        WM_PORT_RUN,
        WM_DAC
    } wmode_e;

    typedef struct packed {
        wmode_e                mode;
        logic [CH_IDX_W-1:0]   ch;
    } sel_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              begin_xfer;
        logic              addr_ok;
        logic              rd;
        logic              byte_ok;
        logic [BYTE_W-1:0] data;
    } xfer_ev_t;

    function automatic sel_t decode_sel(input logic [3:0] code, input logic wide_dac);
        sel_t s;
        s.mode = WM_NONE;
        s.ch   = '0;
        if (code == 4'd0) begin
            s.mode = WM_PORT_ONE;
        end else if (code == 4'hF) begin
            s.mode = WM_PORT_RUN;
        end else if (code <= 4'(CH_HALF)) begin
            s.mode = WM_DAC;
            s.ch   = CH_IDX_W'(code - 4'd1);
        end else if (code <= 4'(CH_TOTAL) && wide_dac) begin
            s.mode = WM_DAC;
            s.ch   = CH_IDX_W'(code - 4'd1);
        end
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] mask_port(input logic [BYTE_W-1:0] v,
                                                   input logic narrow);
        return narrow ? {{(BYTE_W/2){1'b0}}, v[BYTE_W/2-1:0]} : v;
    endfunction

endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync
    import pexp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_in;
                    sda_q <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_in};
                    sda_q <= {sda_q[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.sda   = sda_q[STAGES-1];
        ev.rise  = scl_q[STAGES-1] & ~scl_p;
        ev.fall  = ~scl_q[STAGES-1] & scl_p;
        ev.start = scl_q[STAGES-1] & scl_p & sda_p & ~sda_q[STAGES-1];
        ev.stop  = scl_q[STAGES-1] & scl_p & ~sda_p & sda_q[STAGES-1];
    end
endmodule

// File: rtl/pexp_byte_engine.sv
module pexp_byte_engine
    import pexp_pkg::*;
#(
    parameter logic [3:0] FIXED_HI = 4'b1001
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output xfer_ev_t          xe,
    output logic              sda_low
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;
    logic              nack;
    logic              match;
    logic              full;

    assign match = (sh[BYTE_W-1:1] == {FIXED_HI, strap});
    assign full  = (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            sh   <= '0;
            rw   <= 1'b0;
            nack <= 1'b0;
        end else if (ev.start) begin
            ph  <= PH_ADDR;
            cnt <= '0;
            rw  <= 1'b0;
        end else if (ev.stop) begin
            ph <= PH_IDLE;
        end else begin
            unique case (ph)
                PH_ADDR, PH_RX: begin
                    if (ev.rise && !full) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall && full) begin
                        if (ph == PH_RX) begin
                            ph <= PH_ACK;
                        end else if (match) begin
                            ph <= PH_ACK;
                            rw <= sh[0];
                        end else begin
                            ph <= PH_SKIP;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh <= rd_byte;
                            ph <= PH_TX;
                        end else begin
                            ph <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            ph <= PH_MACK;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.rise) begin
                        nack <= ev.sda;
                    end
                    if (ev.fall) begin
                        if (nack) begin
                            ph <= PH_SKIP;
                        end else begin
                            sh  <= rd_byte;
                            cnt <= '0;
                            ph  <= PH_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        xe.begin_xfer = ev.start;
        xe.addr_ok    = (ph == PH_ADDR) && ev.fall && full && match && !ev.start && !ev.stop;
        xe.rd         = sh[0];
        xe.byte_ok    = (ph == PH_RX) && ev.fall && full && !ev.start && !ev.stop;
        xe.data       = sh;
    end

    assign sda_low = (ph == PH_ACK) || ((ph == PH_TX) && !sh[BYTE_W-1]);
endmodule

// File: rtl/pexp_port_bank.sv
module pexp_port_bank
    import pexp_pkg::*;
#(
    parameter int NUM_CH = CH_TOTAL
) (
    input  logic                     clk,
    input  logic                     rst,
    input  xfer_ev_t                 xe,
    input  logic                     narrow,
    input  logic [BYTE_W-1:0]        port_in,
    output logic [BYTE_W-1:0]        port_out,
    output logic                     port_oe,
    output logic [NUM_CH*BYTE_W-1:0] dac_codes,
    output logic [BYTE_W-1:0]        rd_byte
);
    logic              have_sel;
    sel_t              cur;
    logic [BYTE_W-1:0] port_q;
    logic              oe_q;
    logic              data_ev;
    logic              port_we;
    logic              dac_we;

    assign data_ev = xe.byte_ok && have_sel;
    assign port_we = data_ev && (cur.mode == WM_PORT_ONE || cur.mode == WM_PORT_RUN);
    assign dac_we  = data_ev && (cur.mode == WM_DAC);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_sel <= 1'b0;
            cur      <= '{mode: WM_NONE, ch: '0};
            port_q   <= '0;
            oe_q     <= 1'b0;
        end else begin
            if (xe.begin_xfer) begin
                have_sel <= 1'b0;
                cur.mode <= WM_NONE;
            end else if (xe.byte_ok && !have_sel) begin
                have_sel <= 1'b1;
                cur      <= decode_sel(xe.data[3:0], narrow);
            end else if (data_ev && cur.mode != WM_PORT_RUN) begin
                cur.mode <= WM_NONE;
            end
            if (xe.addr_ok && xe.rd) begin
                oe_q <= 1'b0;
            end else if (port_we) begin
                oe_q   <= 1'b1;
                port_q <= mask_port(xe.data, narrow);
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_lat
            logic [BYTE_W-1:0] code_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q <= '0;
                end else if (dac_we && cur.ch == CH_IDX_W'(i)) begin
                    code_q <= xe.data;
                end
            end
            assign dac_codes[i*BYTE_W +: BYTE_W] = code_q;
        end
    endgenerate

    assign port_out = port_q;
    assign port_oe  = oe_q;
    assign rd_byte  = mask_port(port_in, narrow);
endmodule

// File: rtl/pexp_top.sv
module pexp_top
    import pexp_pkg::*;
#(
    parameter int         NUM_CH      = CH_TOTAL,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] FIXED_HI    = 4'b1001
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     sda_drive_low,
    input  logic [2:0]               addr_strap,
    input  logic [BYTE_W-1:0]        port_in,
    output logic [BYTE_W-1:0]        port_out,
    output logic                     port_oe,
    output logic [NUM_CH*BYTE_W-1:0] dac_codes
);
    bus_ev_t           ev;
    xfer_ev_t          xe;
    logic [BYTE_W-1:0] rd_byte;

    pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    pexp_byte_engine #(.FIXED_HI(FIXED_HI)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (addr_strap),
        .rd_byte (rd_byte),
        .xe      (xe),
        .sda_low (sda_drive_low)
    );

    pexp_port_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .xe        (xe),
        .narrow    (addr_strap[2]),
        .port_in   (port_in),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .dac_codes (dac_codes),
        .rd_byte   (rd_byte)
    );
endmodule

// File: rtl/pexp_checks.sv
module pexp_checks #(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                scl_in,
    input logic                sda_drive_low,
    input logic [2:0]          addr_strap,
    input logic [7:0]          port_out,
    input logic                port_oe,
    input logic [NUM_CH*8-1:0] dac_codes
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!port_oe && !sda_drive_low && port_out == 8'h00));

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        addr_strap[2] |-> (port_out[7:4] == 4'h0));

    a_r3_port_moves_on_ack: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_out) |-> sda_drive_low);

    a_r9_oe_rises_on_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(port_oe) |-> sda_drive_low);

    a_r4_dac_moves_on_ack: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_codes) |-> sda_drive_low);

    a_r11_sda_changes_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_in);
endmodule

bind pexp_top pexp_checks #(.NUM_CH(NUM_CH)) u_checks (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .addr_strap    (addr_strap),
    .port_out      (port_out),
    .port_oe       (port_oe),
    .dac_codes     (dac_codes)
);

// File: tb/tb_pexp_top.sv
module tb_pexp_top;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        tb_low = 1'b0;
    logic [2:0]  strap = 3'b000;
    logic [7:0]  pin = 8'h00;
    logic        sda_drive_low;
    logic [7:0]  port_out;
    logic        port_oe;
    logic [63:0] dac_codes;
    logic        sda_line;

    int vec = 0;
    int bad = 0;

    logic [7:0] exp_port;
    logic       exp_oe;
    logic [7:0] exp_dac [8];
    logic [7:0] wbuf [4];

    assign sda_line = !(tb_low || sda_drive_low);

    always #5 clk = ~clk;

    pexp_top dut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .addr_strap    (strap),
        .port_in       (pin),
        .port_out      (port_out),
        .port_oe       (port_oe),
        .dac_codes     (dac_codes)
    );

    function automatic logic [7:0] pmask(input logic [7:0] v, input logic n);
        return n ? {4'h0, v[3:0]} : v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q_wait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_low = 1'b0; q_wait(1);
        scl = 1'b1;    q_wait(1);
        tb_low = 1'b1; q_wait(1);
        scl = 1'b0;    q_wait(1);
    endtask

    task automatic bus_stop();
        tb_low = 1'b1; q_wait(1);
        scl = 1'b1;    q_wait(1);
        tb_low = 1'b0; q_wait(2);
    endtask

    task automatic put_bit(input logic b);
        tb_low = !b; q_wait(1);
        scl = 1'b1;  q_wait(2);
        scl = 1'b0;  q_wait(1);
    endtask

    task automatic get_bit(output logic b);
        tb_low = 1'b0; q_wait(1);
        scl = 1'b1;    q_wait(1);
        b = sda_line;  q_wait(1);
        scl = 1'b0;    q_wait(1);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic check_state(input string req);
        q_wait(1);
        check({req, " port_out"}, 32'(port_out), 32'(exp_port));
        check({req, " port_oe"}, 32'(port_oe), 32'(exp_oe));
        for (int c = 0; c < 8; c++)
            check({req, " dac"}, 32'(dac_codes[c*8 +: 8]), 32'(exp_dac[c]));
    endtask

    // Model of a write transfer: selector low nibble then data bytes in wbuf
    task automatic model_write(input logic [7:0] sel, input int n);
        logic [3:0] lo = sel[3:0];
        logic nar = strap[2];
        for (int k = 0; k < n; k++) begin
            if (lo == 4'h0 && k == 0) begin
                exp_port = pmask(wbuf[k], nar); exp_oe = 1'b1;
            end else if (lo == 4'hF) begin
                exp_port = pmask(wbuf[k], nar); exp_oe = 1'b1;
            end else if (k == 0 && lo >= 4'd1 && lo <= 4'd4) begin
                exp_dac[lo - 4'd1] = wbuf[k];
            end else if (k == 0 && nar && lo >= 4'd5 && lo <= 4'd8) begin
                exp_dac[lo - 4'd1] = wbuf[k];
            end
        end
    endtask

    task automatic wr_xfer(input string req, input logic [7:0] sel, input int n);
        logic ack;
        bus_start();
        put_byte({4'b1001, strap, 1'b0}, ack);
        check({req, " R11 addr ack"}, 32'(ack), 0);
        put_byte(sel, ack);
        check({req, " R11 sel ack"}, 32'(ack), 0);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], ack);
            check({req, " R11 data ack"}, 32'(ack), 0);
        end
        bus_stop();
        model_write(sel, n);
        check_state(req);
    endtask

    task automatic rd_xfer(input string req, input int n);
        logic ack;
        logic [7:0] v;
        logic [7:0] sampled;
        bus_start();
        put_byte({4'b1001, strap, 1'b1}, ack);
        check({req, " R11 read addr ack"}, 32'(ack), 0);
        sampled = pin;
        for (int k = 0; k < n; k++) begin
            get_byte(v);
            check({req, " R7 read byte"}, 32'(v), 32'(pmask(sampled, strap[2])));
            pin = 8'($urandom);
            sampled = pin;
            put_bit(k == n - 1);
            if (k == n - 1) begin
                q_wait(1);
                check({req, " R7 SDA released after NACK"}, 32'(sda_drive_low), 0);
            end
        end
        bus_stop();
        exp_oe = 1'b0;
        check_state(req);
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst = 1'b1;
        strap = s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        exp_port = 8'h00;
        exp_oe = 1'b0;
        for (int c = 0; c < 8; c++) exp_dac[c] = 8'h00;
        repeat (2) @(negedge clk);
        check("R1 reset sda", 32'(sda_drive_low), 0);
        check_state("R1 reset");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin : main
        logic ack;
        void'($urandom(32'd20240611));
        for (int cfg = 0; cfg < 2; cfg++) begin
            logic [2:0] s = (cfg == 0) ? 3'b010 : 3'b101;
            do_reset(s);

            // R2: wrong address is not acknowledged and changes nothing
            bus_start();
            put_byte({4'b1001, s ^ 3'b001, 1'b0}, ack);
            check("R2 mismatch nack", 32'(ack), 1);
            bus_stop();
            check_state("R2 mismatch");

            // R3 / R8: single port write, extra byte ignored
            wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
            wr_xfer("R3 R8 single port", 8'h70, 2);

            // R4: upper nibble of selector ignored
            wbuf[0] = 8'h11; wbuf[1] = 8'h99;
            wr_xfer("R4 dac ch1", 8'hF1, 2);
            wbuf[0] = 8'hC4;
            wr_xfer("R4 dac ch4", 8'h04, 1);

            // R5: upper channels only in the narrow split
            wbuf[0] = 8'h5E;
            wr_xfer("R5 dac ch5", 8'h05, 1);
            wbuf[0] = 8'h8F;
            wr_xfer("R5 dac ch8", 8'h08, 1);

            // R6: continuous port writes
            wbuf[0] = 8'h01; wbuf[1] = 8'hF2; wbuf[2] = 8'h9B;
            wr_xfer("R6 run", 8'h0F, 3);

            // R7 / R9: read releases port, DAC write keeps it released
            pin = 8'hD6;
            rd_xfer("R7 R9 read", 2);
            wbuf[0] = 8'h42;
            wr_xfer("R9 dac keeps oe low", 8'h02, 1);
            wbuf[0] = 8'h77;
            wr_xfer("R9 port write reenables", 8'h00, 1);

            // R10: unused codes
            wbuf[0] = 8'hEE; wbuf[1] = 8'h12;
            wr_xfer("R10 unused 9", 8'h09, 2);
            wr_xfer("R10 unused E", 8'h0E, 2);

            // random mix
            for (int t = 0; t < 24; t++) begin
                int kind = int'($urandom % 3);
                int n = 1 + int'($urandom % 3);
                for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
                if (kind == 0) begin
                    pin = 8'($urandom);
                    rd_xfer("R7 random read", n);
                end else begin
                    logic [7:0] sel = 8'($urandom);
                    if (kind == 1) sel[3:0] = (($urandom % 2) == 0) ? 4'hF : 4'h0;
                    wr_xfer("R3 R4 R5 R6 R10 random write", sel, n);
                end
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule